// File: doc/BRIEF.md
# Dual-Clock Frequency Calibration Counter

This block compares the frequency of one clock with that of another. A down-counter running on the "down" clock defines a measurement window of a programmed number of its cycles. Across that window, an up-counter running on the "up" clock counts that clock's cycles. When the window closes, the up-count is carried back to the control clock domain. There it is latched as the result and a ready flag is raised. The ratio of the two frequencies is result / window. A longer window gives a finer reading but takes longer to complete.

Software programs the window length, then issues a start command. In single-shot mode the block measures one window and goes idle. In continuous mode it opens a new window as soon as each one ends, and it refreshes the result and sets the ready flag at the end of every window. A stop command halts both counters at any time. The choice of clock sources happens outside the block, so the two measured clocks arrive on dedicated inputs.

Commands travel into the down-clock domain as toggles and are resynchronized there. The window level reaches the up-clock domain through two-flop synchronizers, and the end-of-window event returns to the control domain as a toggle.

Top module: `clkcal_meter`

## Requirements
- R1: After reset, busy_o, rdy_o, ovf_o and irq_o are 0 and result_o is 0.
- R2: A single-shot measurement with window_i = N reports a result within 2 of N * T_down / T_up, where T_down and T_up are the two clock periods. A window_i value of 0 acts as 1.
- R3: In single-shot mode, busy_o is 1 in the cycle after an accepted start_i (start_i while busy_o is 0). It stays 1 until the result is ready, and it falls in the same cycle that rdy_o rises.
- R4: Hardware sets rdy_o when a result is latched. A 1 on rdy_clr_i clears it in the next cycle. If a new result arrives in the same cycle as the clear, the set wins.
- R5: irq_o is 1 exactly when rdy_o is 1 and irq_en_i is 1.
- R6: With cont_i = 1 at start, the block produces a fresh result and raises rdy_o again after every window, with no further start. busy_o falls with the first result and stays 0 while measurements continue.
- R7: stop_i drives busy_o to 0 in the next cycle. No result is latched and rdy_o is not set again until the next start.
- R8: The up-counter saturates at 2^UP_W-1 instead of wrapping. When a latched window saturated, result_o equals 2^UP_W-1 and ovf_o becomes 1. ovf_o stays 1 until the next accepted start.
- R9: result_o changes only in a cycle where rdy_o becomes or stays 1. Clearing rdy_o or stopping leaves result_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset, all domains |
| dn_clk_i | input | 1 | Clock that times the window |
| up_clk_i | input | 1 | Clock being counted |
| window_i | input | DN_W | Window length in down-clock cycles |
| start_i | input | 1 | Start command, one control cycle |
| stop_i | input | 1 | Stop command, one control cycle |
| cont_i | input | 1 | Continuous mode, sampled at start |
| rdy_clr_i | input | 1 | Write-one-to-clear of the ready flag |
| irq_en_i | input | 1 | Ready interrupt enable |
| busy_o | output | 1 | Measurement in progress |
| rdy_o | output | 1 | Result ready flag |
| ovf_o | output | 1 | Sticky up-count saturation flag |
| irq_o | output | 1 | Ready interrupt |
| result_o | output | UP_W | Latched up-count |

## Verification
The assertions take some things about the inputs for granted. window_i stays stable while a measurement runs. Commands are spaced more widely than the synchronizer latency of the slowest clock. Each window lasts several control cycles, so a captured count is still steady when the control domain reads it. The stimulus changes the clock periods and the window only while the block is idle. It leaves at least five control cycles between commands and uses windows long enough to meet that rule, and both random and directed cases pick their periods from bounded ranges.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    RUN_IDLE   = 2'd0,
    RUN_SINGLE = 2'd1,
    RUN_CONT   = 2'd2
  } run_mode_e;
endpackage

// File: rtl/clkcal_sync.sv
module clkcal_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [DEPTH-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/clkcal_down.sv
module clkcal_down
  import clkcal_pkg::*;
#(
  parameter int unsigned DN_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_tgl_i,
  input  logic            stop_tgl_i,
  input  logic            cont_i,
  input  logic [DN_W-1:0] window_i,
  output logic            win_o,
  output logic            end_tgl_o
);
  logic [2:0]      sync_q;
  logic            start_d, stop_d;
  logic            start_e, stop_e;
  logic [DN_W-1:0] cnt_q, load_val;
  logic            win_q, end_tgl_q;

  clkcal_sync #(.WIDTH(3), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cont_i, stop_tgl_i, start_tgl_i}),
    .q_o   (sync_q)
  );

  assign start_e  = sync_q[0] ^ start_d;
  assign stop_e   = sync_q[1] ^ stop_d;
  // zero is treated as a one-cycle window
  assign load_val = (window_i == '0) ? '0 : window_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_d   <= 1'b0;
      stop_d    <= 1'b0;
      cnt_q     <= '0;
      win_q     <= 1'b0;
      end_tgl_q <= 1'b0;
    end else begin
      start_d <= sync_q[0];
      stop_d  <= sync_q[1];
      if (start_e) begin
        cnt_q <= load_val;
        win_q <= 1'b1;
      end else if (stop_e) begin
        win_q <= 1'b0;
      end else if (win_q) begin
        if (cnt_q == '0) begin
          end_tgl_q <= ~end_tgl_q;
          if (sync_q[2]) cnt_q <= load_val;
          else           win_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign win_o     = win_q;
  assign end_tgl_o = end_tgl_q;
endmodule

// File: rtl/clkcal_up.sv
module clkcal_up
  import clkcal_pkg::*;
#(
  parameter int unsigned UP_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            win_i,
  input  logic            end_tgl_i,
  output logic [UP_W-1:0] hold_o,
  output logic            hold_ovf_o,
  output logic            cap_tgl_o
);
  logic [1:0]      sync_q;
  logic            win_d, end_d;
  logic            win_s, end_e, win_rise;
  logic [UP_W-1:0] ucnt_q, hold_q, ucnt_inc;
  logic            ovf_q, hold_ovf_q, cap_tgl_q, at_max;

  clkcal_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({end_tgl_i, win_i}),
    .q_o   (sync_q)
  );

  assign win_s    = sync_q[0];
  assign end_e    = sync_q[1] ^ end_d;
  assign win_rise = win_s & ~win_d;
  assign at_max   = &ucnt_q;
  assign ucnt_inc = at_max ? ucnt_q : ucnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_d      <= 1'b0;
      end_d      <= 1'b0;
      ucnt_q     <= '0;
      ovf_q      <= 1'b0;
      hold_q     <= '0;
      hold_ovf_q <= 1'b0;
      cap_tgl_q  <= 1'b0;
    end else begin
      win_d <= win_s;
      end_d <= sync_q[1];
      if (end_e) begin
        hold_q     <= ucnt_q;
        hold_ovf_q <= ovf_q;
        cap_tgl_q  <= ~cap_tgl_q;
        ucnt_q     <= {{(UP_W-1){1'b0}}, win_s};
        ovf_q      <= 1'b0;
      end else if (win_rise) begin
        ucnt_q <= {{(UP_W-1){1'b0}}, 1'b1};
        ovf_q  <= 1'b0;
      end else if (win_s) begin
        ucnt_q <= ucnt_inc;
        ovf_q  <= ovf_q | at_max;
      end
    end
  end

  assign hold_o     = hold_q;
  assign hold_ovf_o = hold_ovf_q;
  assign cap_tgl_o  = cap_tgl_q;
endmodule

// File: rtl/clkcal_ctrl.sv
module clkcal_ctrl
  import clkcal_pkg::*;
#(
  parameter int unsigned UP_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            cont_i,
  input  logic            rdy_clr_i,
  input  logic            irq_en_i,
  input  logic [UP_W-1:0] hold_i,
  input  logic            hold_ovf_i,
  input  logic            cap_tgl_i,
  output logic            start_tgl_o,
  output logic            stop_tgl_o,
  output logic            cont_o,
  output logic            busy_o,
  output logic            rdy_o,
  output logic            ovf_o,
  output logic            irq_o,
  output logic [UP_W-1:0] result_o
);
  run_mode_e       mode_q;
  logic            cap_s, cap_d, cap_e;
  logic            start_ok, take;
  logic            start_tgl_q, stop_tgl_q, busy_q, rdy_q, ovf_q;
  logic [UP_W-1:0] result_q;

  clkcal_sync #(.WIDTH(1), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cap_tgl_i),
    .q_o   (cap_s)
  );

  assign cap_e    = cap_s ^ cap_d;
  assign start_ok = start_i & ~busy_q & ~stop_i;
  // a capture is dropped when idle or when a command owns the cycle
  assign take     = cap_e & (mode_q != RUN_IDLE) & ~stop_i & ~start_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_d       <= 1'b0;
      mode_q      <= RUN_IDLE;
      start_tgl_q <= 1'b0;
      stop_tgl_q  <= 1'b0;
      busy_q      <= 1'b0;
      ovf_q       <= 1'b0;
      result_q    <= '0;
    end else begin
      cap_d <= cap_s;
      if (stop_i) begin
        stop_tgl_q <= ~stop_tgl_q;
        busy_q     <= 1'b0;
        mode_q     <= RUN_IDLE;
      end else if (start_ok) begin
        start_tgl_q <= ~start_tgl_q;
        busy_q      <= 1'b1;
        ovf_q       <= 1'b0;
        mode_q      <= cont_i ? RUN_CONT : RUN_SINGLE;
      end else if (take) begin
        result_q <= hold_i;
        ovf_q    <= ovf_q | hold_ovf_i;
        busy_q   <= 1'b0;
        if (mode_q == RUN_SINGLE) mode_q <= RUN_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdy_q <= 1'b0;
    else if (take)      rdy_q <= 1'b1;
    else if (rdy_clr_i) rdy_q <= 1'b0;
  end

  assign start_tgl_o = start_tgl_q;
  assign stop_tgl_o  = stop_tgl_q;
  assign cont_o      = (mode_q == RUN_CONT);
  assign busy_o      = busy_q;
  assign rdy_o       = rdy_q;
  assign ovf_o       = ovf_q;
  assign irq_o       = rdy_q & irq_en_i;
  assign result_o    = result_q;
endmodule

// File: rtl/clkcal_meter.sv
module clkcal_meter #(
  parameter int unsigned DN_W = 16,
  parameter int unsigned UP_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dn_clk_i,
  input  logic            up_clk_i,
  input  logic [DN_W-1:0] window_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            cont_i,
  input  logic            rdy_clr_i,
  input  logic            irq_en_i,
  output logic            busy_o,
  output logic            rdy_o,
  output logic            ovf_o,
  output logic            irq_o,
  output logic [UP_W-1:0] result_o
);
  logic            start_tgl, stop_tgl, cont_lvl;
  logic            win, end_tgl, cap_tgl, hold_ovf;
  logic [UP_W-1:0] hold;

  clkcal_ctrl #(.UP_W(UP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .cont_i     (cont_i),
    .rdy_clr_i  (rdy_clr_i),
    .irq_en_i   (irq_en_i),
    .hold_i     (hold),
    .hold_ovf_i (hold_ovf),
    .cap_tgl_i  (cap_tgl),
    .start_tgl_o(start_tgl),
    .stop_tgl_o (stop_tgl),
    .cont_o     (cont_lvl),
    .busy_o     (busy_o),
    .rdy_o      (rdy_o),
    .ovf_o      (ovf_o),
    .irq_o      (irq_o),
    .result_o   (result_o)
  );

  clkcal_down #(.DN_W(DN_W)) u_down (
    .clk_i      (dn_clk_i),
    .rst_ni     (rst_ni),
    .start_tgl_i(start_tgl),
    .stop_tgl_i (stop_tgl),
    .cont_i     (cont_lvl),
    .window_i   (window_i),
    .win_o      (win),
    .end_tgl_o  (end_tgl)
  );

  clkcal_up #(.UP_W(UP_W)) u_up (
    .clk_i     (up_clk_i),
    .rst_ni    (rst_ni),
    .win_i     (win),
    .end_tgl_i (end_tgl),
    .hold_o    (hold),
    .hold_ovf_o(hold_ovf),
    .cap_tgl_o (cap_tgl)
  );
endmodule

// File: rtl/clkcal_meter_chk.sv
module clkcal_meter_chk #(
  parameter int unsigned UP_W = 20
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            stop_i,
  input logic            rdy_clr_i,
  input logic            irq_en_i,
  input logic            busy_o,
  input logic            rdy_o,
  input logic            ovf_o,
  input logic            irq_o,
  input logic [UP_W-1:0] result_o
);
  a_r3_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !stop_i) |=> busy_o);

  a_r3_busy_ends_with_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (rdy_o || $past(stop_i)));

  a_r4_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(rdy_clr_i));

  a_r5_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && rdy_o));

  a_r7_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_o);

  a_r8_saturated_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (result_o == {UP_W{1'b1}}));

  a_r9_result_with_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> rdy_o);
endmodule

bind clkcal_meter clkcal_meter_chk #(.UP_W(UP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .stop_i   (stop_i),
  .rdy_clr_i(rdy_clr_i),
  .irq_en_i (irq_en_i),
  .busy_o   (busy_o),
  .rdy_o    (rdy_o),
  .ovf_o    (ovf_o),
  .irq_o    (irq_o),
  .result_o (result_o)
);

// File: tb/clkcal_meter_tb.sv
`timescale 1ns/1ps
module clkcal_meter_tb;
  localparam int DN_W = 12;
  localparam int UP_W = 12;
  localparam int UMAX = (1 << UP_W) - 1;

  logic clk = 1'b0, dn_clk = 1'b0, up_clk = 1'b0, rst_n = 1'b0;
  real  dn_half = 8.0, up_half = 5.0;
  logic [DN_W-1:0] window = '0;
  logic start = 1'b0, stop = 1'b0, cont = 1'b0, rdy_clr = 1'b0, irq_en = 1'b0;
  logic busy, rdy, ovf, irq;
  logic [UP_W-1:0] result;
  int runs = 0, fails = 0;

  always #5 clk = ~clk;
  initial forever #(dn_half) dn_clk = ~dn_clk;
  initial forever #(up_half) up_clk = ~up_clk;

  clkcal_meter #(.DN_W(DN_W), .UP_W(UP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dn_clk_i(dn_clk), .up_clk_i(up_clk),
    .window_i(window), .start_i(start), .stop_i(stop), .cont_i(cont),
    .rdy_clr_i(rdy_clr), .irq_en_i(irq_en), .busy_o(busy), .rdy_o(rdy),
    .ovf_o(ovf), .irq_o(irq), .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_cnt(input int n, input real dh, input real uh);
    int v;
    v = $rtoi((n == 0 ? 1 : n) * dh / uh);
    return (v > UMAX) ? UMAX : v;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic clear_rdy();
    rdy_clr = 1'b1; @(negedge clk); rdy_clr = 1'b0;
  endtask

  task automatic wait_rdy(input int lim, output bit got);
    got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (rdy) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic near(input string req, input int act, input int exp);
    int d;
    d = act - exp;
    if (d < 0) d = -d;
    chk(d <= 2, req, "count", act, exp);
  endtask

  task automatic single(input int n, input real dh, input real uh);
    bit got;
    int e;
    dn_half = dh; up_half = uh; window = DN_W'(n);
    tick(5);
    pulse_start();
    chk(busy == 1'b1, "R3", "busy after start", int'(busy), 1);
    wait_rdy($rtoi(n * dh / 5.0) + 80, got);
    chk(got, "R2", "result ready", int'(got), 1);
    chk(busy == 1'b0, "R3", "busy falls with ready", int'(busy), 0);
    e = exp_cnt(n, dh, uh);
    near("R2", int'(result), e);
    clear_rdy();
    chk(rdy == 1'b0, "R4", "flag cleared", int'(rdy), 0);
  endtask

  initial begin
    bit got;
    int snap, e;
    void'($urandom(32'd2417));
    tick(3);
    chk(busy == 0, "R1", "busy", int'(busy), 0);
    chk(rdy == 0, "R1", "rdy", int'(rdy), 0);
    chk(ovf == 0, "R1", "ovf", int'(ovf), 0);
    chk(irq == 0, "R1", "irq", int'(irq), 0);
    chk(result == 0, "R1", "result", int'(result), 0);
    rst_n = 1'b1;
    tick(5);

    single(100, 8.0, 5.0);
    single(1, 8.0, 5.0);
    single(0, 8.0, 5.0);

    // R5 interrupt gating
    irq_en = 1'b1;
    window = 12'd50; tick(5); pulse_start();
    wait_rdy(200, got);
    tick(1);
    chk(irq == 1'b1, "R5", "irq enabled", int'(irq), 1);
    irq_en = 1'b0; tick(1);
    chk(irq == 1'b0, "R5", "irq masked", int'(irq), 0);
    irq_en = 1'b1; tick(1);
    snap = int'(result);
    clear_rdy();
    chk(irq == 1'b0, "R5", "irq after clear", int'(irq), 0);
    chk(int'(result) == snap, "R9", "result after clear", int'(result), snap);
    irq_en = 1'b0;

    // random single-shot windows
    for (int k = 0; k < 8; k++) begin
      single(20 + int'($urandom % 181), real'(3 + $urandom % 10), real'(2 + $urandom % 8));
    end

    // R8 saturation and sticky overflow
    single(1200, 10.0, 2.5);
    chk(int'(result) == UMAX, "R8", "saturated result", int'(result), UMAX);
    chk(ovf == 1'b1, "R8", "ovf set", int'(ovf), 1);
    tick(3);
    chk(ovf == 1'b1, "R8", "ovf sticky", int'(ovf), 1);
    dn_half = 8.0; up_half = 5.0; window = 12'd40; tick(5);
    pulse_start();
    chk(ovf == 1'b0, "R8", "ovf cleared by start", int'(ovf), 0);
    wait_rdy(200, got);
    near("R2", int'(result), exp_cnt(40, 8.0, 5.0));
    clear_rdy();

    // R6 continuous mode
    dn_half = 6.0; up_half = 4.0; window = 12'd80; cont = 1'b1; tick(5);
    e = exp_cnt(80, 6.0, 4.0);
    pulse_start();
    cont = 1'b0;
    wait_rdy(400, got);
    chk(got, "R6", "first result", int'(got), 1);
    near("R6", int'(result), e);
    clear_rdy();
    wait_rdy(400, got);
    chk(got, "R6", "second result without start", int'(got), 1);
    chk(busy == 1'b0, "R6", "busy low while running", int'(busy), 0);
    near("R6", int'(result), e);
    clear_rdy();
    wait_rdy(400, got);
    chk(got, "R6", "third result", int'(got), 1);

    // R7 stop halts
    stop = 1'b1; rdy_clr = 1'b1; @(negedge clk); stop = 1'b0; rdy_clr = 1'b0;
    chk(busy == 1'b0, "R7", "busy after stop", int'(busy), 0);
    snap = int'(result);
    tick(400);
    chk(rdy == 1'b0, "R7", "no ready after stop", int'(rdy), 0);
    chk(int'(result) == snap, "R9", "result held after stop", int'(result), snap);

    // restart single-shot after stop
    single(60, 7.0, 3.0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    runs++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule